// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block is the interrupt arbitration slice of a 16550-style UART register file. It watches four interrupt causes: a receiver line-status error event, a received-data-ready or trigger-reached level, the transmit holding register being empty, and a modem-status change level. Each cause is gated by its enable bit. The highest-ranked pending cause is encoded into the value that software reads from the interrupt identification register. The block also drives the single interrupt line to the interrupt controller.

The register-file decoder tells the block when software reads the line status register, reads the identification register, or writes the transmit holding register. Those accesses clear the matching sticky interrupt flags. When the receive FIFO is enabled, the FIFO-mode tag is merged into the upper bits of the identification value.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit 0 gates received data, bit 1 gates transmit-empty, bit 2 gates line status and bit 3 gates modem status. A source whose enable bit is 0 never shows up in `iir_o` and never raises `irq_o`.
- R2: After reset, with every input at 0, `iir_o` reads 0x01 and `irq_o` is 0.
- R3: `iir_o[3:0]` reads 0x1 when nothing is pending. It reads 0x6 for a line-status error, 0x4 for received data, 0x2 for transmit-empty and 0x0 for a modem-status change.
- R4: `iir_o[7:6]` reads 2'b11 while `fifo_en_i` is 1 and 2'b00 otherwise. Bits 5:4 read 0, and bits 3:0 do not depend on `fifo_en_i`.
- R5: When several enabled sources are pending, the one shown is chosen in this order, highest first: line status, received data, transmit-empty, modem status.
- R6: A one-cycle `line_err_i` pulse sets a line-status flag that holds until a cycle with `lsr_rd_i` high. After that read, a pending received-data condition is shown as 0x4. If `line_err_i` and `lsr_rd_i` are both high in the same cycle, the flag stays set.
- R7: The transmit-empty flag is set in the cycle after `thr_empty_i & ier_i[1]` goes from 0 to 1. It is cleared by `thr_wr_i`. While `thr_empty_i` stays high it is not set again, so code 0x2 only appears while `thr_empty_i` and `ier_i[1]` are both 1.
- R8: An `iir_rd_i` cycle clears the transmit-empty flag only when `iir_o[3:0]` reads 0x2 in that cycle. A read while a different code is shown leaves the flag set.
- R9: `irq_o` is always the inverse of `iir_o[0]`.
- R10: A line-status error event is latched even while `ier_i[2]` is 0. Setting the enable bit later, without any read of the line status register in between, shows code 0x6 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Interrupt enable bits (rx, tx-empty, line status, modem) |
| fifo_en_i | input | 1 | FIFO mode is enabled |
| rx_avail_i | input | 1 | Receive data ready or trigger level reached |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| line_err_i | input | 1 | One-cycle line error event (overrun, parity, framing, break) |
| msr_chg_i | input | 1 | Modem-status change pending |
| lsr_rd_i | input | 1 | Line status register read strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_o | output | 8 | Identification register read value |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A table of level-only patterns sweeps enable masks against the received-data and modem levels, with FIFO mode both on and off. This separates enable gating from code encoding, and it separates the FIFO tag from the low bits. Directed sequences then exercise the sticky flags. An error that arrives while received data is pending shows whether line status wins and what a status read uncovers. A rising transmit-empty condition is cleared by a write, by a matching identification read and by a non-matching one, which shows which access clears which flag. An error event that arrives while its enable is off shows that the flag is latched independently of the enable.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC  = 4;               // index 0 is highest priority
  localparam int ID_W     = $clog2(NUM_SRC);
  localparam int IIR_W    = 8;

  typedef enum logic [1:0] {
    SRC_LINE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_THRE = 2'd2,
    SRC_MDM  = 2'd3
  } src_e;

  // identification field value for a given priority slot
  function automatic logic [ID_W-1:0] slot_id(input int slot);
    return ID_W'(NUM_SRC - 1 - slot);
  endfunction
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_err_i,
  input  logic lsr_rd_i,
  input  logic thre_arm_i,
  input  logic thre_clr_i,
  output logic line_pend_o,
  output logic thre_pend_o
);
  logic line_q, thre_q, arm_q;
  logic thre_rise;

  assign thre_rise = thre_arm_i & ~arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      thre_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= thre_arm_i;
      // new error wins over a concurrent read
      if (line_err_i)    line_q <= 1'b1;
      else if (lsr_rd_i) line_q <= 1'b0;
      if (thre_clr_i || !thre_arm_i) thre_q <= 1'b0;
      else if (thre_rise)             thre_q <= 1'b1;
    end
  end

  assign line_pend_o = line_q;
  assign thre_pend_o = thre_q;

  AST_LINE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !line_err_i) |=> !line_pend_o); // R6
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_pend_o && !lsr_rd_i) |=> line_pend_o); // R6
  AST_THRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_clr_i |=> !thre_pend_o); // R7
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N   = NUM_SRC,
  parameter int IDW = ID_W
) (
  input  logic [N-1:0]   req_i,
  output logic [N-1:0]   sel_o,
  output logic [IDW-1:0] id_o,
  output logic           none_o
);
  logic [N:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_slot
    assign above[i+1] = above[i] | req_i[i];
    assign sel_o[i]   = req_i[i] & ~above[i];
  end

  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++)
      if (sel_o[i]) id_o = id_o | IDW'(N - 1 - i);
  end

  assign none_o = ~above[N];

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(sel_o)); // R5
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       ier_i,
  input  logic             fifo_en_i,
  input  logic             rx_avail_i,
  input  logic             thr_empty_i,
  input  logic             line_err_i,
  input  logic             msr_chg_i,
  input  logic             lsr_rd_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  output logic [IIR_W-1:0] iir_o,
  output logic             irq_o
);
  localparam logic [ID_W-1:0] THRE_ID = slot_id(int'(SRC_THRE));

  logic              line_pend, thre_pend, thre_arm, thre_clr, none;
  logic [NUM_SRC-1:0] req, sel;
  logic [ID_W-1:0]   id;

  assign thre_arm = thr_empty_i & ier_i[1];
  // iir read only consumes the tx-empty cause when that is what it returns
  assign thre_clr = thr_wr_i | (iir_rd_i & ~none & (id == THRE_ID));

  uart_irq_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_err_i  (line_err_i),
    .lsr_rd_i    (lsr_rd_i),
    .thre_arm_i  (thre_arm),
    .thre_clr_i  (thre_clr),
    .line_pend_o (line_pend),
    .thre_pend_o (thre_pend)
  );

  assign req[SRC_LINE] = line_pend   & ier_i[2];
  assign req[SRC_RX]   = rx_avail_i  & ier_i[0];
  assign req[SRC_THRE] = thre_pend   & thre_arm;
  assign req[SRC_MDM]  = msr_chg_i   & ier_i[3];

  uart_irq_prio #(.N(NUM_SRC), .IDW(ID_W)) u_prio (
    .req_i  (req),
    .sel_o  (sel),
    .id_o   (id),
    .none_o (none)
  );

  always_comb begin
    iir_o      = '0;
    iir_o[7:6] = {2{fifo_en_i}};
    iir_o[3:1] = 3'(id);
    iir_o[0]   = none;
  end

  assign irq_o = |sel;

  AST_NO_ENABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == 4'h0) |-> (iir_o[0] && !irq_o)); // R1
  AST_THRE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[3:0] == 4'h2) |-> (thr_empty_i && ier_i[1])); // R7
  AST_THRE_WR_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> (iir_o[3:0] != 4'h2)); // R7
  AST_IRQ_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != iir_o[0]); // R9
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ier_i = '0;
  logic       fifo_en_i = 1'b0, rx_avail_i = 1'b0, thr_empty_i = 1'b0;
  logic       line_err_i = 1'b0, msr_chg_i = 1'b0;
  logic       lsr_rd_i = 1'b0, iir_rd_i = 1'b0, thr_wr_i = 1'b0;
  logic [7:0] iir_o;
  logic       irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  uart_irq_ident u_uart_irq_ident (
    .clk_i(clk_i), .rst_ni(rst_ni), .ier_i(ier_i), .fifo_en_i(fifo_en_i),
    .rx_avail_i(rx_avail_i), .thr_empty_i(thr_empty_i), .line_err_i(line_err_i),
    .msr_chg_i(msr_chg_i), .lsr_rd_i(lsr_rd_i), .iir_rd_i(iir_rd_i),
    .thr_wr_i(thr_wr_i), .iir_o(iir_o), .irq_o(irq_o)
  );

  // {ier[3:0], fifo, rx, msr, 0, expected iir}
  localparam logic [15:0] VEC [8] = '{
    16'h0601,  // R1 nothing enabled
    16'h1404,  // R3 rx code
    16'h8200,  // R3 modem code
    16'h9604,  // R5 rx over modem
    16'h98C1,  // R4 fifo idle
    16'h9CC4,  // R4 fifo rx
    16'h8AC0,  // R4 fifo modem
    16'h6601   // R1 levels present but disabled
  };

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (iir_o !== exp) begin
      n_bad++;
      $display("FAIL %s iir act=%02h exp=%02h", req, iir_o, exp);
    end
    n_chk++;
    if (irq_o !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s irq act=%0b exp=%0b", req, irq_o, ~exp[0]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk("R2", 8'h01);

    foreach (VEC[i]) begin
      ier_i = VEC[i][15:12]; fifo_en_i = VEC[i][11];
      rx_avail_i = VEC[i][10]; msr_chg_i = VEC[i][9];
      #1;
      chk("R1/R3/R4/R5/R9 table", VEC[i][7:0]);
    end
    fifo_en_i = 0; rx_avail_i = 0; msr_chg_i = 0;

    // R5 R6 line status over rx, cleared by lsr read
    ier_i = 4'h7; rx_avail_i = 1; line_err_i = 1; tick(); line_err_i = 0;
    chk("R5", 8'h06);
    tick(); chk("R6 hold", 8'h06);
    lsr_rd_i = 1; line_err_i = 1; tick(); line_err_i = 0; lsr_rd_i = 0;
    chk("R6 set wins", 8'h06);
    lsr_rd_i = 1; tick(); lsr_rd_i = 0;
    chk("R6 cleared", 8'h04);
    rx_avail_i = 0; #1; chk("R6 idle", 8'h01);

    // R10 latched while disabled
    ier_i = 4'h1; line_err_i = 1; tick(); line_err_i = 0;
    chk("R10 masked", 8'h01);
    ier_i = 4'h4; #1; chk("R10 enabled", 8'h06);
    lsr_rd_i = 1; tick(); lsr_rd_i = 0; chk("R10 clear", 8'h01);

    // R7 rising tx-empty, cleared by write, no re-arm
    ier_i = 4'h2; thr_empty_i = 1; tick();
    chk("R7 set", 8'h02);
    thr_wr_i = 1; tick(); thr_wr_i = 0;
    chk("R7 wr clr", 8'h01);
    tick(); chk("R7 no rearm", 8'h01);

    // R7 enable rise while empty
    ier_i = 4'h0; tick(); ier_i = 4'h2; tick();
    chk("R7 enable rise", 8'h02);
    ier_i = 4'hA; msr_chg_i = 1; #1;
    chk("R5 thre over modem", 8'h02);
    msr_chg_i = 0;

    // R8 iir read clears only when 0x2 is shown
    ier_i = 4'h3; rx_avail_i = 1; #1; chk("R8 rx shown", 8'h04);
    iir_rd_i = 1; tick(); iir_rd_i = 0; rx_avail_i = 0; #1;
    chk("R8 kept", 8'h02);
    iir_rd_i = 1; tick(); iir_rd_i = 0;
    chk("R8 cleared", 8'h01);

    fifo_en_i = 1; #1; chk("R4 fifo idle", 8'hC1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule